// File: doc/BRIEF.md
# USB Interrupt Flag and Mask Unit

This block sits between the event outputs of a USB device controller and the CPU interrupt inputs. Single-cycle event pulses are captured into three 8-bit sticky flag groups: common bus events, endpoint 0 together with the IN endpoints, and the OUT endpoints. Each group has its own enable mask. A global enable gates the combined USB interrupt request. Software reads a flag group through a small register port. The read returns the flags and empties the whole group in the same step, so the value read has to be kept by software.

Resume signalling from the bus is kept off the USB request line. A rising edge on the resume input sets the resume flag in the common group. When the wake-up enable is set, the same edge also produces a one-cycle pulse on a separate wake-up interrupt output. That output can bring the CPU out of a low-power state while the USB request line stays quiet.

Register map (3-bit address): 0 = common flags, 1 = endpoint 0 / IN flags, 2 = OUT flags, 3 = reads as zero, 4/5/6 = masks for groups 0/1/2, 7 = control. In the control register, bit 0 is the global USB interrupt enable and bit 1 is the wake-up enable. In the common group, bit 0 is suspend, bit 1 is resume, bit 2 is bus reset and bit 3 is start-of-frame.

Top module: `usb_irq_unit`

## Requirements
- R1: A read of address 0, 1 or 2 returns that group's flags as they stood before the read's clock edge.
- R2: A read of a flag group clears all eight flags of that group at the same edge. Reads of addresses 3 to 7 clear nothing.
- R3: After reset all flags are 0 and the control register is 0. The common mask reads 0xF6, with suspend bit 0 and start-of-frame bit 3 disabled. The endpoint 0 / IN mask and the OUT mask read 0xFF.
- R4: `usb_irq` is a level that is 1 exactly when control bit 0 is 1 and some flag is set whose mask bit is also 1, the resume flag excepted. It drops in the cycle after the read that clears the last such flag.
- R5: An event that pulses in the same cycle as a read-clear of its group is kept, and it shows on the next read.
- R6: An event pulse sets its flag whatever the mask holds. Flags stay set until their group is read.
- R7: A rising edge on `resume_line` produces a single one-cycle `wake_irq` pulse in the cycle after the edge is sampled, but only when control bit 1 is 1. A line that is held high does not fire again.
- R8: A rising edge on `resume_line` sets common flag bit 1 whether or not the wake-up enable is set. That flag never drives `usb_irq`, and `evt_common[1]` has no effect.
- R9: Writes to addresses 0 to 3 change no flag. Writes to 4, 5 and 6 load the masks, and a write to 7 loads the control bits.
- R10: `rdata` is registered. It takes the read value at the edge where `rd_en` is sampled high and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_common | input | 8 | Common event pulses (bit 1 ignored) |
| evt_in | input | 8 | Endpoint 0 / IN endpoint event pulses |
| evt_out | input | 8 | OUT endpoint event pulses |
| resume_line | input | 1 | Resume signalling detected on the bus (level) |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Registered read data |
| usb_irq | output | 1 | Level USB interrupt request |
| wake_irq | output | 1 | One-cycle resume wake-up interrupt |

## Verification
Flags, masks and control take an event or a write at the clock edge where it is sampled. `usb_irq` follows combinationally from those registers, so it is due just after that same edge. `rdata` and `wake_irq` also change at the edge where the read, or the resume edge, is sampled. The bench drives every input on the falling edge and advances its reference model at the rising edge from the pre-edge inputs. It then samples all outputs two nanoseconds after that rising edge, which keeps every comparison aligned with the cycle each result is due.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
   localparam int NUM_GRP = 3;
   typedef enum logic [1:0] {
      GRP_COMMON = 2'd0,
      GRP_EPIN   = 2'd1,
      GRP_EPOUT  = 2'd2
   } grp_e;
   localparam int MASK_BASE = 4;
   localparam int CTRL_ADDR = 7;
endpackage

// File: rtl/usb_irq_bank.sv
module usb_irq_bank #(
   parameter int              DATA_W   = 8,
   parameter logic [DATA_W-1:0] MASK_RST = '1,
   parameter logic [DATA_W-1:0] EXCL     = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt,
   input  logic              clr,
   input  logic              mask_we,
   input  logic [DATA_W-1:0] mask_wdata,
   output logic [DATA_W-1:0] flags,
   output logic [DATA_W-1:0] mask,
   output logic              req
);
   if (DATA_W < 1) begin : g_bad_width
      $error("usb_irq_bank: DATA_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         mask  <= MASK_RST;
      end else begin
         flags <= (clr ? '0 : flags) | evt;
         if (mask_we) mask <= mask_wdata;
      end
   end

   assign req = |(flags & mask & ~EXCL);

   // R2 / R5: a clear leaves only what arrived in that very cycle
   a_r5_clear_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flags == $past(evt)));
   // R6: every pulsed event lands in the register
   a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((flags & $past(evt)) == $past(evt)));
   // R6: without a clear no flag falls
   a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/usb_irq_wake.sv
module usb_irq_wake (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic en,
   output logic rise,
   output logic wake_irq
);
   logic line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q   <= 1'b0;
         wake_irq <= 1'b0;
      end else begin
         line_q   <= line;
         wake_irq <= rise & en;
      end
   end

   assign rise = line & ~line_q;

   // R7: wake-up is a single-cycle pulse
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |=> !wake_irq);
   // R7: no pulse unless the enable was set at the edge
   a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> $past(en));
endmodule

// File: rtl/usb_irq_regif.sv
module usb_irq_regif
   import usb_irq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rd_en,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]               wdata,
   input  logic [NUM_GRP-1:0][DATA_W-1:0]  flags,
   input  logic [NUM_GRP-1:0][DATA_W-1:0]  masks,
   output logic [NUM_GRP-1:0]              clr,
   output logic [NUM_GRP-1:0]              mask_we,
   output logic                            gen_en,
   output logic                            wake_en,
   output logic [DATA_W-1:0]               rdata
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("usb_irq_regif: ADDR_W must be at least 3");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("usb_irq_regif: DATA_W must be at least 2");
   end

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   logic [DATA_W-1:0] rd_val;
   logic              unused_wdata;

   assign unused_wdata = ^wdata[DATA_W-1:2];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
      assign clr[g]     = rd_en && (addr == ADDR_W'(g));
      assign mask_we[g] = wr_en && (addr == ADDR_W'(MASK_BASE + g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_en  <= 1'b0;
         wake_en <= 1'b0;
      end else if (wr_en && addr == CTRL_A) begin
         gen_en  <= wdata[0];
         wake_en <= wdata[1];
      end
   end

   always_comb begin
      rd_val = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (addr == ADDR_W'(g))             rd_val = flags[g];
         if (addr == ADDR_W'(MASK_BASE + g)) rd_val = masks[g];
      end
      if (addr == CTRL_A) rd_val = DATA_W'({wake_en, gen_en});
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end

   // R10: read data only moves on a read
   a_r10_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
   // R2: at most one group is cleared, and only by a read
   a_r2_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr));
endmodule

// File: rtl/usb_irq_unit.sv
module usb_irq_unit
   import usb_irq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int SUSPEND_BIT = 0,
   parameter int RESUME_BIT  = 1,
   parameter int RESET_BIT   = 2,
   parameter int SOF_BIT     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_common,
   input  logic [DATA_W-1:0] evt_in,
   input  logic [DATA_W-1:0] evt_out,
   input  logic              resume_line,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              usb_irq,
   output logic              wake_irq
);
   if (SUSPEND_BIT >= DATA_W || RESUME_BIT >= DATA_W ||
       RESET_BIT >= DATA_W || SOF_BIT >= DATA_W) begin : g_bad_bits
      $error("usb_irq_unit: common bit positions exceed DATA_W");
   end
   if (SUSPEND_BIT == RESUME_BIT || SUSPEND_BIT == RESET_BIT ||
       SUSPEND_BIT == SOF_BIT || RESUME_BIT == RESET_BIT ||
       RESUME_BIT == SOF_BIT || RESET_BIT == SOF_BIT) begin : g_dup_bits
      $error("usb_irq_unit: common bit positions must differ");
   end

   localparam logic [DATA_W-1:0] RESUME_ONE = DATA_W'(1) << RESUME_BIT;
   localparam logic [DATA_W-1:0] COMMON_MASK_RST =
      ~((DATA_W'(1) << SOF_BIT) | (DATA_W'(1) << SUSPEND_BIT));

   logic [NUM_GRP-1:0][DATA_W-1:0] grp_evt;
   logic [NUM_GRP-1:0][DATA_W-1:0] grp_flags;
   logic [NUM_GRP-1:0][DATA_W-1:0] grp_mask;
   logic [NUM_GRP-1:0]             grp_clr;
   logic [NUM_GRP-1:0]             grp_mask_we;
   logic [NUM_GRP-1:0]             grp_req;
   logic                           gen_en;
   logic                           wake_en;
   logic                           resume_rise;

   usb_irq_wake u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .line     (resume_line),
      .en       (wake_en),
      .rise     (resume_rise),
      .wake_irq (wake_irq)
   );

   assign grp_evt[GRP_COMMON] = (evt_common & ~RESUME_ONE) |
                                (resume_rise ? RESUME_ONE : '0);
   assign grp_evt[GRP_EPIN]   = evt_in;
   assign grp_evt[GRP_EPOUT]  = evt_out;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
      localparam logic [DATA_W-1:0] M_RST = (g == 0) ? COMMON_MASK_RST : '1;
      localparam logic [DATA_W-1:0] X_MSK = (g == 0) ? RESUME_ONE : '0;
      usb_irq_bank #(
         .DATA_W   (DATA_W),
         .MASK_RST (M_RST),
         .EXCL     (X_MSK)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .evt        (grp_evt[g]),
         .clr        (grp_clr[g]),
         .mask_we    (grp_mask_we[g]),
         .mask_wdata (wdata),
         .flags      (grp_flags[g]),
         .mask       (grp_mask[g]),
         .req        (grp_req[g])
      );
   end

   usb_irq_regif #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regif (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .flags   (grp_flags),
      .masks   (grp_mask),
      .clr     (grp_clr),
      .mask_we (grp_mask_we),
      .gen_en  (gen_en),
      .wake_en (wake_en),
      .rdata   (rdata)
   );

   assign usb_irq = gen_en & (|grp_req);

   // R4: the request never rises without the global enable
   a_r4_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
      usb_irq |-> gen_en);
   // R4: with no read and no write the level holds
   a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_irq && !rd_en && !wr_en) |=> usb_irq);
   // R8: a resume edge alone never raises the USB request
   a_r8_resume_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!usb_irq && resume_rise && !rd_en && !wr_en &&
       evt_common == '0 && evt_in == '0 && evt_out == '0) |=> !usb_irq);
endmodule

// File: tb/usb_irq_unit_bench.sv
module usb_irq_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] evt_common, evt_in, evt_out, wdata, rdata;
   logic       resume_line, rd_en, wr_en, usb_irq, wake_irq;
   logic [2:0] addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] m_flag [3];
   logic [7:0] m_mask [3];
   logic       m_gen, m_wen, m_prev, m_wake;

   always #4 clk = ~clk;

   usb_irq_unit u_usb_irq_unit (
      .clk(clk), .rst_n(rst_n), .evt_common(evt_common), .evt_in(evt_in),
      .evt_out(evt_out), .resume_line(resume_line), .rd_en(rd_en),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .usb_irq(usb_irq), .wake_irq(wake_irq)
   );

   function automatic logic exp_irq();
      logic any = 1'b0;
      for (int g = 0; g < 3; g++) begin
         logic [7:0] m = (g == 0) ? (m_mask[g] & 8'hFD) : m_mask[g];
         any |= |(m_flag[g] & m);
      end
      return m_gen & any;
   endfunction

   function automatic logic [7:0] exp_read(input logic [2:0] a);
      if (a <= 3'd2)                  return m_flag[a];
      if (a >= 3'd4 && a <= 3'd6)     return m_mask[a - 3'd4];
      if (a == 3'd7)                  return {6'b0, m_wen, m_gen};
      return 8'h00;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int g = 0; g < 3; g++) begin
         m_flag[g] = 8'h00;
         m_mask[g] = 8'hFF;
      end
      m_mask[0] = 8'hF6;
      m_gen = 1'b0; m_wen = 1'b0; m_prev = 1'b0; m_wake = 1'b0;
   endtask

   task automatic cyc(input string tag, input logic rd, input logic wr,
                      input logic [2:0] a, input logic [7:0] wd,
                      input logic [7:0] ec, input logic [7:0] ei,
                      input logic [7:0] eo, input logic line);
      logic [7:0] exp_rd;
      logic       rise;
      @(negedge clk);
      rd_en = rd; wr_en = wr; addr = a; wdata = wd;
      evt_common = ec; evt_in = ei; evt_out = eo; resume_line = line;
      @(posedge clk);
      exp_rd = exp_read(a);
      rise   = line & ~m_prev;
      m_wake = rise & m_wen;
      m_prev = line;
      if (rd && a <= 3'd2) m_flag[a] = 8'h00;
      m_flag[0] |= (ec & 8'hFD) | (rise ? 8'h02 : 8'h00);
      m_flag[1] |= ei;
      m_flag[2] |= eo;
      if (wr && a >= 3'd4 && a <= 3'd6) m_mask[a - 3'd4] = wd;
      if (wr && a == 3'd7) begin
         m_gen = wd[0];
         m_wen = wd[1];
      end
      #2;
      if (rd) check({tag, " rdata"}, rdata, exp_rd);
      check({tag, " usb_irq"}, {7'b0, usb_irq}, {7'b0, exp_irq()});
      check({tag, " wake_irq"}, {7'b0, wake_irq}, {7'b0, m_wake});
   endtask

   task automatic idle(input string tag, input logic line);
      cyc(tag, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, line);
   endtask

   task automatic rd(input string tag, input logic [2:0] a);
      cyc(tag, 1'b1, 1'b0, a, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
   endtask

   task automatic wr(input string tag, input logic [2:0] a, input logic [7:0] d);
      cyc(tag, 1'b0, 1'b1, a, d, 8'h00, 8'h00, 8'h00, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240517));
      rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
      evt_common = '0; evt_in = '0; evt_out = '0; resume_line = 1'b0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R3 reset usb_irq", {7'b0, usb_irq}, 8'h00);
      check("R3 reset wake_irq", {7'b0, wake_irq}, 8'h00);
      rd("R3 common mask", 3'd4);
      rd("R3 in mask", 3'd5);
      rd("R3 out mask", 3'd6);
      rd("R3 control", 3'd7);
      rd("R3 flags", 3'd0);

      // R4: flags collect while the global enable is off
      cyc("R4 gen off", 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h21, 8'h00, 1'b0);
      rd("R1 in flags", 3'd1);
      rd("R2 in flags cleared", 3'd1);

      wr("R9 control on", 3'd7, 8'h01);
      cyc("R4 out event", 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h20, 1'b0);
      idle("R4 level holds", 1'b0);
      idle("R4 level holds", 1'b0);
      rd("R4 clear drops irq", 3'd2);
      idle("R4 low after clear", 1'b0);

      // R6: start-of-frame is masked at reset yet still recorded
      cyc("R6 sof masked", 1'b0, 1'b0, 3'd0, 8'h00, 8'h08, 8'h00, 8'h00, 1'b0);
      rd("R6 sof recorded", 3'd0);

      // R5: event together with its group's clear survives
      cyc("R5 pre", 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0);
      cyc("R5 same cycle", 1'b1, 1'b0, 3'd1, 8'h00, 8'h00, 8'h80, 8'h00, 1'b0);
      rd("R5 next read", 3'd1);

      // R8: resume edge with wake disabled
      idle("R8 line high", 1'b1);
      idle("R8 line held", 1'b1);
      rd("R8 resume flag", 3'd0);
      cyc("R8 ignored bit", 1'b0, 1'b0, 3'd0, 8'h00, 8'h02, 8'h00, 8'h00, 1'b0);
      rd("R8 bit1 ignored", 3'd0);

      // R7: wake enable and a held line
      wr("R9 control wake", 3'd7, 8'h03);
      idle("R7 rise", 1'b1);
      idle("R7 held", 1'b1);
      idle("R7 held", 1'b1);
      idle("R7 low", 1'b0);
      idle("R7 rise again", 1'b1);
      idle("R7 low", 1'b0);
      rd("R7 resume flag", 3'd0);

      // R9: writes to flag addresses do nothing
      cyc("R9 event", 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h11, 1'b0);
      wr("R9 write flags", 3'd2, 8'h00);
      wr("R9 write reserved", 3'd3, 8'hFF);
      rd("R9 flags kept", 3'd2);
      wr("R9 mask write", 3'd5, 8'h0F);
      rd("R9 mask readback", 3'd5);
      rd("R10 second read", 3'd3);
      idle("R10 hold", 1'b0);
      check("R10 rdata held", rdata, 8'h00);

      for (int i = 0; i < 3000; i++) begin
         logic       r  = ($urandom % 5) == 0;
         logic       w  = ($urandom % 9) == 0;
         logic [2:0] a  = 3'($urandom);
         logic [7:0] d  = 8'($urandom);
         logic [7:0] ec = (($urandom % 4) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
         logic [7:0] ei = (($urandom % 4) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
         logic [7:0] eo = (($urandom % 4) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
         logic       ln = ($urandom % 3) == 0;
         cyc("R1 random", r, w, a, d, ec, ei, eo, ln);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule